// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block holds the eight-bit status word of a serial flash device and enforces the rules that decide when that word may change. It sits beside the command decoder. The decoder hands it one-cycle strobes for each completed command: write enable, write disable, status-write enable, status write with its data byte, any other command, operation start and done, and entry into and exit from word-program mode. The block answers with the current status byte for status reads, a write-enable flag, an erase-all permission, and a combinational `addr_protected` verdict for a queried address and byte count.

The four block-protection bits select a region aligned to the top of the array. Its size is a power-of-two fraction of a parameterised array size. A status write is accepted only when the command just before it armed it. It is further gated by the write-protect pin together with the lock bit, and by the busy flag.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte reads 0x1C: bits 2, 3 and 4 set and every other bit clear. `write_en` is 0 and `erase_all_ok` is 0.
- R2: Status bit layout: bit 0 busy, bit 1 write-enable latch, bits 5:2 protection code (bit 2 least significant), bit 6 word-program mode, bit 7 lock. A status write changes only bits 7 and 5:2. Bits 0, 1 and 6 are never taken from the written data.
- R3: Protection code bits 4:2 give the protected region at the top of an array of 2^AW bytes. 0 gives nothing. A code c from 1 to 6 gives the top 2^AW / 2^(7-c) bytes. 7 gives the whole array. Bit 5 has no effect on the region.
- R4: `addr_protected` is 1 exactly when `q_bytes` is non-zero and some byte from `q_addr` to `q_addr+q_bytes-1` lies in the protected region.
- R5: A status write updates bits 7 and 5:2 only if the command strobe just before it was write enable or status-write enable. Any other command strobe in between disarms it.
- R6: With `wp_n` low and bit 7 set, a status write leaves bits 7 and 5:2 unchanged. With `wp_n` low and bit 7 clear, a write may set bit 7. With `wp_n` high, bit 7 does not block writes.
- R7: One accepted status write can set bit 7 and change bits 5:2 together. Every status write strobe taken while not busy clears the write-enable latch.
- R8: Write enable sets the latch when not busy. Write disable clears both the latch and word-program mode.
- R9: The operation-done strobe clears the latch when not in word-program mode and leaves it set while in that mode. Word-program exit clears both the latch and the mode bit.
- R10: Operation start sets busy and operation done clears it. A status write strobe arriving while busy has no effect on any status bit.
- R11: `erase_all_ok` is 1 exactly when all four bits 5:2 are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Write-enable command completed |
| cmd_wrdi | input | 1 | Write-disable command completed |
| cmd_ewsr | input | 1 | Status-write-enable command completed |
| cmd_other | input | 1 | Any other command completed |
| wrsr_stb | input | 1 | Status-write command completed |
| wrsr_data | input | 8 | Data byte of the status write |
| op_start | input | 1 | Internal program/erase started |
| op_done | input | 1 | Internal program/erase finished |
| aai_enter | input | 1 | Word-program mode entered |
| aai_exit | input | 1 | Word-program mode ended |
| q_addr | input | AW | Query start address |
| q_bytes | input | AW+1 | Query length in bytes |
| status | output | 8 | Status byte |
| write_en | output | 1 | Write-enable latch |
| addr_protected | output | 1 | Query overlaps the protected region |
| erase_all_ok | output | 1 | Whole-array erase permitted |

## Verification
The bench walks the region boundaries of every protection code, one byte below and one byte at the region base. It also runs a multi-byte query that starts outside and ends inside, a zero-length query, and codes with only bit 5 set. A decoder off by one fraction, or one that read bit 5, would misreport those edges. Directed cases go after an arming command separated from the status write by another command, a lock that is set while the pin is low and then cannot be undone, and a status write issued while busy. Further cases cover the latch kept through an operation completing in word-program mode and an erase permission that wrongly ignores bit 5. A controller that mishandled any of these would leave the array writable when it should not be, or lock out a legal write.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_BP_LO = 2;
  localparam int ST_BP_HI = 5;
  localparam int ST_AAI  = 6;
  localparam int ST_LOCK = 7;
  localparam int BP_W    = ST_BP_HI - ST_BP_LO + 1;
  localparam logic [7:0] STATUS_RESET = 8'h1C;
  localparam logic [BP_W-1:0] BP_RESET = STATUS_RESET[ST_BP_HI:ST_BP_LO];

  typedef struct packed {
    logic            lock;
    logic            aai;
    logic [BP_W-1:0] bp;
    logic            wel;
    logic            busy;
  } stat_t;
endpackage

// File: rtl/fsr_prot_decode.sv
module fsr_prot_decode #(
  parameter int AW = 22
) (
  input  logic [2:0]  code,
  input  logic [AW-1:0] q_addr,
  input  logic [AW:0]   q_bytes,
  output logic          prot
);
  localparam int SW = AW + 2;
  localparam logic [SW-1:0] ARRAY = SW'(1) << AW;

  // Size in bytes of the top region selected by a three-bit code.
  function automatic logic [SW-1:0] region_bytes(input logic [2:0] c);
    logic [SW-1:0] r;
    if (c == 3'd0) r = '0;
    else           r = ARRAY >> (3'd7 - c);
    return r;
  endfunction

  // First protected byte address (equals ARRAY when nothing is protected).
  function automatic logic [SW-1:0] region_base(input logic [2:0] c);
    return ARRAY - region_bytes(c);
  endfunction

  logic [SW-1:0] end_excl;
  logic [SW-1:0] base;

  always_comb begin
    base     = region_base(code);
    end_excl = SW'(q_addr) + SW'(q_bytes);
    prot     = (code != 3'd0) && (q_bytes != '0) && (end_excl > base);
  end
endmodule

// File: rtl/fsr_wr_gate.sv
module fsr_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_ewsr,
  input  logic cmd_other,
  input  logic wrsr_stb,
  input  logic cur_lock,
  input  logic cur_busy,
  output logic wrsr_seen,
  output logic wrsr_take
);
  logic armed;
  logic locked;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else if (cmd_wren || cmd_ewsr) armed <= 1'b1;
    else if (cmd_wrdi || cmd_other || wrsr_stb) armed <= 1'b0;
  end

  assign locked    = !wp_n && cur_lock;
  assign wrsr_seen = wrsr_stb && !cur_busy;
  assign wrsr_take = wrsr_seen && armed && !locked;

  // R5: a write with no arming command just before it is never taken
  p_unarmed_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_other && !cmd_wren && !cmd_ewsr) |=> !wrsr_take);
endmodule

// File: rtl/fsr_regs.sv
module fsr_regs
  import flash_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wren,
  input  logic       cmd_wrdi,
  input  logic       op_start,
  input  logic       op_done,
  input  logic       aai_enter,
  input  logic       aai_exit,
  input  logic       wrsr_seen,
  input  logic       wrsr_take,
  input  logic [7:0] wrsr_data,
  output stat_t      st
);
  logic wel_clr;
  logic wel_set;

  assign wel_clr = cmd_wrdi || wrsr_seen || aai_exit || (op_done && !st.aai);
  assign wel_set = cmd_wren && !st.busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.busy <= 1'b0;
      st.wel  <= 1'b0;
      st.aai  <= 1'b0;
      st.bp   <= BP_RESET;
      st.lock <= 1'b0;
    end else begin
      if (op_start)     st.busy <= 1'b1;
      else if (op_done) st.busy <= 1'b0;

      if (wel_clr)      st.wel <= 1'b0;
      else if (wel_set) st.wel <= 1'b1;

      if (cmd_wrdi || aai_exit) st.aai <= 1'b0;
      else if (aai_enter)       st.aai <= 1'b1;

      if (wrsr_take) begin
        st.bp   <= wrsr_data[ST_BP_HI:ST_BP_LO];
        st.lock <= wrsr_data[ST_LOCK];
      end
    end
  end

  p_wrdi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdi |=> (!st.wel && !st.aai));
  p_wren_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !st.busy && !op_done && !aai_exit) |=> st.wel);
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> st.busy);
  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_start) |=> !st.busy);
  p_refused_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrsr_take) |=> ($stable(st.bp) && $stable(st.lock)));
  p_wrsr_clears_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_seen |=> !st.wel);
  p_aai_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aai_exit |=> (!st.aai && !st.wel));
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import flash_stat_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_ewsr,
  input  logic          cmd_other,
  input  logic          wrsr_stb,
  input  logic [7:0]    wrsr_data,
  input  logic          op_start,
  input  logic          op_done,
  input  logic          aai_enter,
  input  logic          aai_exit,
  input  logic [AW-1:0] q_addr,
  input  logic [AW:0]   q_bytes,
  output logic [7:0]    status,
  output logic          write_en,
  output logic          addr_protected,
  output logic          erase_all_ok
);
  stat_t st;
  logic  wrsr_seen;
  logic  wrsr_take;

  fsr_wr_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .cmd_wren  (cmd_wren),
    .cmd_wrdi  (cmd_wrdi),
    .cmd_ewsr  (cmd_ewsr),
    .cmd_other (cmd_other),
    .wrsr_stb  (wrsr_stb),
    .cur_lock  (st.lock),
    .cur_busy  (st.busy),
    .wrsr_seen (wrsr_seen),
    .wrsr_take (wrsr_take)
  );

  fsr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wren  (cmd_wren),
    .cmd_wrdi  (cmd_wrdi),
    .op_start  (op_start),
    .op_done   (op_done),
    .aai_enter (aai_enter),
    .aai_exit  (aai_exit),
    .wrsr_seen (wrsr_seen),
    .wrsr_take (wrsr_take),
    .wrsr_data (wrsr_data),
    .st        (st)
  );

  fsr_prot_decode #(.AW(AW)) u_dec (
    .code    (st.bp[2:0]),
    .q_addr  (q_addr),
    .q_bytes (q_bytes),
    .prot    (addr_protected)
  );

  assign status       = st;
  assign write_en     = st.wel;
  assign erase_all_ok = (st.bp == '0);

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_stb && !wp_n && status[ST_LOCK]) |=>
      ($stable(status[ST_BP_HI:ST_BP_LO]) && $stable(status[ST_LOCK])));
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_stb && status[ST_BUSY] && !op_done && !cmd_wren) |=> $stable(write_en));
  p_all_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4:2] == 3'd7 && q_bytes != '0) |-> addr_protected);
  p_no_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4:2] == 3'd0) |-> !addr_protected);
  p_erase_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all_ok |-> !addr_protected);
endmodule

// File: tb/flash_status_ctl_tb.sv
`timescale 1ns/1ps
module flash_status_ctl_tb;
  localparam int AW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_ewsr = 0, cmd_other = 0, wrsr_stb = 0;
  logic [7:0] wrsr_data = '0;
  logic op_start = 0, op_done = 0, aai_enter = 0, aai_exit = 0;
  logic [AW-1:0] q_addr = '0;
  logic [AW:0]   q_bytes = '0;
  logic [7:0] status;
  logic write_en, addr_protected, erase_all_ok;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_status_ctl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_ewsr(cmd_ewsr),
    .cmd_other(cmd_other), .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .op_start(op_start), .op_done(op_done), .aai_enter(aai_enter),
    .aai_exit(aai_exit), .q_addr(q_addr), .q_bytes(q_bytes),
    .status(status), .write_en(write_en), .addr_protected(addr_protected),
    .erase_all_ok(erase_all_ok)
  );

  // {code[3:0], addr[21:0], bytes[22:0], expected}
  localparam int NV = 17;
  localparam logic [49:0] VEC [NV] = '{
    {4'h0, 22'h3FFFFF, 23'd1,      1'b0},
    {4'h1, 22'h3F0000, 23'd1,      1'b1},
    {4'h1, 22'h3EFFFF, 23'd1,      1'b0},
    {4'h1, 22'h3EFFFF, 23'd2,      1'b1},
    {4'h2, 22'h3E0000, 23'd1,      1'b1},
    {4'h2, 22'h3DFFFF, 23'd1,      1'b0},
    {4'h3, 22'h3C0000, 23'd1,      1'b1},
    {4'h3, 22'h3BFFFF, 23'd1,      1'b0},
    {4'h4, 22'h37FFFF, 23'd1,      1'b0},
    {4'h4, 22'h380000, 23'd1,      1'b1},
    {4'h5, 22'h300000, 23'd1,      1'b1},
    {4'h5, 22'h2FFFFF, 23'd1,      1'b0},
    {4'h6, 22'h1FFFFF, 23'd1,      1'b0},
    {4'h6, 22'h1FFFFF, 23'h001000, 1'b1},
    {4'h7, 22'h000000, 23'd1,      1'b1},
    {4'h8, 22'h3FFFFF, 23'd1,      1'b0},
    {4'h9, 22'h3F0000, 23'd0,      1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic write_st(input logic [7:0] d);
    wrsr_data = d;
    pulse(wrsr_stb);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 erase refused
    chk("R1 status", status, 8'h1C);
    chk("R1 write_en", write_en, 0);
    chk("R11 erase_all_ok reset", erase_all_ok, 0);

    // R5 write without arming ignored
    write_st(8'h00);
    chk("R5 unarmed", status, 8'h1C);
    pulse(cmd_wren); pulse(cmd_other); write_st(8'h00);
    chk("R5 disarmed by other", status, 8'h1C);

    // R5 arming by status-write enable
    pulse(cmd_ewsr); write_st(8'h00);
    chk("R5 ewsr armed", status, 8'h00);
    chk("R11 erase_all_ok clear", erase_all_ok, 1);

    // R2/R7 lock and protection in one write, read-only bits untouched
    pulse(cmd_wren);
    chk("R8 wren sets", status, 8'h02);
    write_st(8'hFF);
    chk("R2 R7 write ff", status, 8'hBC);
    chk("R7 wel cleared", write_en, 0);

    // R6 lock with pin low
    wp_n = 1'b0;
    pulse(cmd_ewsr); write_st(8'h00);
    chk("R6 locked refuse", status, 8'hBC);
    wp_n = 1'b1;
    pulse(cmd_ewsr); write_st(8'h00);
    chk("R6 pin high ignores lock", status, 8'h00);
    wp_n = 1'b0;
    pulse(cmd_ewsr); write_st(8'h84);
    chk("R6 set lock with pin low", status, 8'h84);
    pulse(cmd_ewsr); write_st(8'h00);
    chk("R6 lock not undone", status, 8'h84);
    wp_n = 1'b1;
    pulse(cmd_ewsr); write_st(8'h20);
    chk("R3 bit5 only status", status, 8'h20);
    chk("R11 bit5 blocks erase", erase_all_ok, 0);
    pulse(cmd_ewsr); write_st(8'h00);

    // R8 write disable, word-program mode
    pulse(cmd_wren); pulse(cmd_wrdi);
    chk("R8 wrdi clears wel", status, 8'h00);
    pulse(cmd_wren); pulse(aai_enter);
    chk("R8 aai entered", status, 8'h42);
    pulse(cmd_wrdi);
    chk("R8 wrdi clears aai", status, 8'h00);

    // R9/R10 operation lifecycle
    pulse(cmd_wren); pulse(op_start);
    chk("R10 busy set", status, 8'h03);
    pulse(op_done);
    chk("R9 done clears wel", status, 8'h00);
    pulse(cmd_wren); pulse(aai_enter); pulse(op_start);
    chk("R10 busy in aai", status, 8'h43);
    pulse(op_done);
    chk("R9 wel kept in aai", status, 8'h42);
    pulse(aai_exit);
    chk("R9 aai exit", status, 8'h00);

    // R10 status write while busy ignored
    pulse(op_start);
    pulse(cmd_ewsr); write_st(8'h3C);
    chk("R10 busy write ignored", status, 8'h01);
    pulse(op_done);
    chk("R10 busy cleared", status, 8'h00);

    // R3/R4 region table
    for (int i = 0; i < NV; i++) begin
      pulse(cmd_wren);
      write_st({2'b00, VEC[i][49:46], 2'b00});
      q_addr  = VEC[i][45:24];
      q_bytes = VEC[i][23:1];
      @(negedge clk);
      chk($sformatf("R3 R4 vector %0d", i), addr_protected, VEC[i][0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule